// File: doc/BRIEF.md
# Predicated Dual-Vector Word Load Sequencer

This block carries out one contiguous load of 32-bit words into a pair of adjacent vector registers, under the control of a predicate. The predicate is supplied as a count of leading active elements. The block widens that count into one enable bit per element, covering both destination vectors. For each enabled element it issues one word read on a simple request/response memory port. When every element has been resolved, it writes the two vectors through a register-file write port.

An operation starts with a one-cycle `start` pulse while the block is idle. The operation carries these operands:

- a base address;
- a signed immediate, scaled by the vector length in bytes;
- the number of the first destination register;
- the predicate count.

Disabled elements never reach memory and are written as zero. A faulting response ends the operation without touching the register file. An odd first register number is rejected at once.

The vector length `VLEN` is a parameter, from 128 to 2048 bits.

Top module: `vload_seq`

## Requirements
- R1: Element i, with i from 0 to NE-1 (NE = VLEN/32), occupies bits [32*i+31:32*i] of register N. Element NE+j occupies bits [32*j+31:32*j] of register N+1.
- R2: If the first destination register number is odd, `illegal` and `done` pulse together on the cycle after `start`. No memory request is issued and no register is written.
- R3: For a predicate count K, elements 0 to K-1 are enabled. K values of 2*NE or more enable all 2*NE elements.
- R4: No memory request is ever issued for a disabled element.
- R5: A disabled element can never be the source of a fault, even when its address would fault.
- R6: A disabled element is written to its register as zero.
- R7: The start address is base + sign-extended immediate * (VLEN/8). Element i reads the word address start + 4*i, which is always word aligned.
- R8: Requests go out in ascending element order. A new request is issued only after the response to the previous one has arrived.
- R9: A fault response ends the operation. `fault` and `done` then pulse together, `fault_elem` holds the index of the faulting element, and no register is written.
- R10: On success, register N is written in one cycle and register N+1 in the following cycle. `done` pulses on the cycle after the second write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| base_addr | input | AW | Base address |
| imm | input | IMM_W | Signed immediate, in units of the vector length |
| dst_reg | input | RIDX_W | First destination register number |
| pred_cnt | input | PCNT_W | Predicate in count form |
| mem_req_valid | output | 1 | Word read request |
| mem_req_addr | output | AW | Request byte address |
| mem_rsp_valid | input | 1 | Response strobe |
| mem_rsp_data | input | 32 | Response word |
| mem_rsp_fault | input | 1 | Response reports a fault |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | RIDX_W | Register written |
| rf_wdata | output | VLEN | Vector written |
| done | output | 1 | Operation finished (any outcome) |
| illegal | output | 1 | Odd first register number was rejected |
| fault | output | 1 | Operation aborted by a fault response |
| fault_elem | output | EIW | Index of the faulting element |

## Verification
Two events can fall in the same response cycle: an element's memory response, and the decision between storing that element and aborting the operation. A second overlap is between a fault address that has been armed and an element that is disabled. The bench places the faulting address on an enabled element in one operation and on a disabled element in another. It judges each case by comparing requests, register writes and the `fault`/`done` pulses against queues built from the requirements. The saturated, zero and negative-immediate operations also check that the widened predicate splits correctly at the boundary between the two registers.

// File: rtl/vload_pkg.sv
// Shared types for the predicated dual-vector load sequencer.
package vload_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_WAIT,
        ST_WR_LO,
        ST_WR_HI
    } seq_state_t;
endpackage

// File: rtl/vload_pred_expand.sv
// Widens a count-form predicate into one enable bit per element.
// Assumes: bit g is set when the count exceeds g, so large counts saturate.
module vload_pred_expand #(
    parameter int NT     = 8,
    parameter int PCNT_W = 8
) (
    input  logic [PCNT_W-1:0] cnt_i,
    output logic [NT-1:0]     mask_o
);
    for (genvar g = 0; g < NT; g++) begin : g_bit
        // Element g is enabled when it lies below the count.
        assign mask_o[g] = (32'(cnt_i) > g);
    end
endmodule

// File: rtl/vload_addr_gen.sv
// Address arithmetic: start address from base and scaled immediate, and
// per-element word address. Assumes VLEN/8 is a power of two.
module vload_addr_gen #(
    parameter int AW    = 32,
    parameter int IMM_W = 4,
    parameter int VLEN  = 128,
    parameter int EIW   = 4
) (
    input  logic [AW-1:0]    base_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [AW-1:0]    start_q_i,
    input  logic [EIW-1:0]   idx_i,
    output logic [AW-1:0]    start_o,
    output logic [AW-1:0]    elem_addr_o
);
    localparam int VB_SH = $clog2(VLEN / 8);

    logic [AW-1:0] imm_ext;

    // Sign-extend the immediate to address width.
    assign imm_ext     = {{(AW - IMM_W){imm_i[IMM_W-1]}}, imm_i};
    // Start address: base plus immediate times vector bytes.
    assign start_o     = base_i + (imm_ext << VB_SH);
    // Element address: start plus four bytes per element.
    assign elem_addr_o = start_q_i + (AW'(idx_i) << 2);
endmodule

// File: rtl/vload_elem_buffer.sv
// Holds the loaded words of both destination vectors. Clearing zeroes every
// lane, so lanes never written remain zero.
module vload_elem_buffer #(
    parameter int NE  = 4,
    parameter int LW  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              wr_i,
    input  logic [LW-1:0]     lane_i,
    input  logic [31:0]       data_i,
    output logic [32*NE-1:0]  lo_o,
    output logic [32*NE-1:0]  hi_o
);
    localparam int NT = 2 * NE;

    logic [31:0] lane_q [NT];

    for (genvar g = 0; g < NT; g++) begin : g_lane
        // Per-lane storage: zeroed on reset or clear, loaded on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i) begin
                lane_q[g] <= '0;
            end else if (wr_i && (32'(lane_i) == g)) begin
                lane_q[g] <= data_i;
            end
        end
        if (g < NE) begin : g_lo
            assign lo_o[32*g +: 32] = lane_q[g];
        end else begin : g_hi
            assign hi_o[32*(g-NE) +: 32] = lane_q[g];
        end
    end
endmodule

// File: rtl/vload_seq.sv
// Predicated dual-vector word load sequencer (top).
// Accepts one operation at a time, walks the elements in ascending order with
// at most one outstanding read, then writes register N and N+1.
// Assumes memory answers every request exactly once, in a later cycle.
module vload_seq #(
    parameter int AW     = 32,
    parameter int IMM_W  = 4,
    parameter int VLEN   = 128,
    parameter int RIDX_W = 5,
    parameter int PCNT_W = 8,
    parameter int NE     = VLEN / 32,
    parameter int NT     = 2 * NE,
    parameter int EIW    = $clog2(NT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     base_addr,
    input  logic [IMM_W-1:0]  imm,
    input  logic [RIDX_W-1:0] dst_reg,
    input  logic [PCNT_W-1:0] pred_cnt,
    output logic              mem_req_valid,
    output logic [AW-1:0]     mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    input  logic              mem_rsp_fault,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic [VLEN-1:0]   rf_wdata,
    output logic              done,
    output logic              illegal,
    output logic              fault,
    output logic [EIW-1:0]    fault_elem
);
    import vload_pkg::*;

    localparam int LW = $clog2(NT);

    seq_state_t        state_q;
    logic [EIW-1:0]    idx_q;
    logic [NT-1:0]     mask_q;
    logic [NT-1:0]     mask_new;
    logic [AW-1:0]     start_q;
    logic [AW-1:0]     start_new;
    logic [RIDX_W-1:0] dst_q;
    logic [VLEN-1:0]   vec_lo;
    logic [VLEN-1:0]   vec_hi;
    logic              at_end;
    logic              cur_on;
    logic              accept;
    logic              buf_wr;

    vload_pred_expand #(.NT(NT), .PCNT_W(PCNT_W)) u_expand (
        .cnt_i  (pred_cnt),
        .mask_o (mask_new)
    );

    vload_addr_gen #(.AW(AW), .IMM_W(IMM_W), .VLEN(VLEN), .EIW(EIW)) u_addr (
        .base_i      (base_addr),
        .imm_i       (imm),
        .start_q_i   (start_q),
        .idx_i       (idx_q),
        .start_o     (start_new),
        .elem_addr_o (mem_req_addr)
    );

    vload_elem_buffer #(.NE(NE), .LW(LW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .wr_i    (buf_wr),
        .lane_i  (idx_q[LW-1:0]),
        .data_i  (mem_rsp_data),
        .lo_o    (vec_lo),
        .hi_o    (vec_hi)
    );

    // Decode the current element: past the end, or enabled.
    always_comb begin
        at_end = (32'(idx_q) >= NT);
        cur_on = !at_end && mask_q[idx_q[LW-1:0]];
    end

    // Operation acceptance and element-buffer write strobe.
    assign accept = (state_q == ST_IDLE) && start && !dst_reg[0];
    assign buf_wr = (state_q == ST_WAIT) && mem_rsp_valid && !mem_rsp_fault;

    // Memory request and register-file write port.
    always_comb begin
        mem_req_valid = (state_q == ST_SCAN) && cur_on;
        rf_we         = (state_q == ST_WR_LO) || (state_q == ST_WR_HI);
        rf_waddr      = (state_q == ST_WR_HI) ? {dst_q[RIDX_W-1:1], 1'b1} : dst_q;
        rf_wdata      = (state_q == ST_WR_HI) ? vec_hi : vec_lo;
    end

    // Sequencer state, operand capture and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            idx_q      <= '0;
            mask_q     <= '0;
            start_q    <= '0;
            dst_q      <= '0;
            done       <= 1'b0;
            illegal    <= 1'b0;
            fault      <= 1'b0;
            fault_elem <= '0;
        end else begin
            done    <= 1'b0;
            illegal <= 1'b0;
            fault   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start && dst_reg[0]) begin
                        illegal <= 1'b1;
                        done    <= 1'b1;
                    end else if (accept) begin
                        mask_q  <= mask_new;
                        start_q <= start_new;
                        dst_q   <= dst_reg;
                        idx_q   <= '0;
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (at_end) begin
                        state_q <= ST_WR_LO;
                    end else if (cur_on) begin
                        state_q <= ST_WAIT;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_fault) begin
                            fault      <= 1'b1;
                            fault_elem <= idx_q;
                            done       <= 1'b1;
                            state_q    <= ST_IDLE;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= ST_SCAN;
                        end
                    end
                end
                ST_WR_LO: state_q <= ST_WR_HI;
                ST_WR_HI: begin
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vload_seq_chk.sv
// Property checker for vload_seq, attached through bind.
module vload_seq_chk #(
    parameter int AW     = 32,
    parameter int RIDX_W = 5,
    parameter int NT     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_valid,
    input logic [AW-1:0]     mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              rf_we,
    input logic [RIDX_W-1:0] rf_waddr,
    input logic              done,
    input logic              illegal,
    input logic              fault,
    input logic [NT-1:0]     mask_q,
    input logic [AW-1:0]     start_q
);
    localparam int LW = $clog2(NT);

    logic [AW-1:0] elem_off;
    // Element number recovered from the request address.
    assign elem_off = (mem_req_addr - start_q) >> 2;

    assert_req_only_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mask_q[elem_off[LW-1:0]]);

    assert_req_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

    assert_single_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    assert_illegal_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !rf_we && !mem_req_valid && !fault));

    assert_fault_after_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (done && !rf_we && $past(mem_rsp_valid)));

    assert_write_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && !rf_waddr[0]) |=> (rf_we && rf_waddr == $past(rf_waddr) + 1'b1));

    assert_done_after_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_waddr[0]) |=> (done && !rf_we));
endmodule

bind vload_seq vload_seq_chk #(.AW(AW), .RIDX_W(RIDX_W), .NT(NT)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .rf_we         (rf_we),
    .rf_waddr      (rf_waddr),
    .done          (done),
    .illegal       (illegal),
    .fault         (fault),
    .mask_q        (mask_q),
    .start_q       (start_q)
);

// File: tb/vload_seq_tb_top.sv
// Bench for vload_seq: behavioural queues of expected requests and writes,
// compared at every negative clock edge.
module vload_seq_tb_top;
    localparam int AW = 32, IMM_W = 4, VLEN = 128, RIDX_W = 5, PCNT_W = 8;
    localparam int NE = VLEN / 32, NT = 2 * NE, EIW = $clog2(NT + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [AW-1:0]     base_addr = '0;
    logic [IMM_W-1:0]  imm = '0;
    logic [RIDX_W-1:0] dst_reg = '0;
    logic [PCNT_W-1:0] pred_cnt = '0;
    logic              mem_req_valid;
    logic [AW-1:0]     mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [31:0]       mem_rsp_data = '0;
    logic              mem_rsp_fault = 1'b0;
    logic              rf_we;
    logic [RIDX_W-1:0] rf_waddr;
    logic [VLEN-1:0]   rf_wdata;
    logic              done, illegal, fault;
    logic [EIW-1:0]    fault_elem;

    int checks = 0;
    int failures = 0;

    logic [AW-1:0]     req_q[$];
    logic [RIDX_W-1:0] wa_q[$];
    logic [VLEN-1:0]   wd_q[$];
    logic              flt_en = 1'b0;
    logic [AW-1:0]     flt_addr = '0;

    always #4 clk = ~clk;

    vload_seq #(.AW(AW), .IMM_W(IMM_W), .VLEN(VLEN), .RIDX_W(RIDX_W), .PCNT_W(PCNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .imm(imm),
        .dst_reg(dst_reg), .pred_cnt(pred_cnt), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_fault(mem_rsp_fault), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .done(done), .illegal(illegal),
        .fault(fault), .fault_elem(fault_elem)
    );

    function automatic logic [31:0] memfn(input logic [AW-1:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Memory responder: answers each request after an address-dependent latency.
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_fault = 1'b0;
            if (mem_req_valid) begin
                logic [AW-1:0] a;
                a = mem_req_addr;
                repeat (1 + int'(a[3:2]) % 3) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = memfn(a);
                mem_rsp_fault = flt_en && (a == flt_addr);
            end
        end
    end

    // Per-cycle monitor: requests and writes against the expected queues.
    always @(negedge clk) begin
        if (rst_n && mem_req_valid) begin
            if (req_q.size() == 0) begin
                chk(1'b0, "R4", "unexpected request", longint'(mem_req_addr), 0);
            end else begin
                chk(mem_req_addr == req_q[0], "R7/R8", "request address",
                    longint'(mem_req_addr), longint'(req_q[0]));
                void'(req_q.pop_front());
            end
        end
        if (rst_n && rf_we) begin
            if (wa_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected write", longint'(rf_waddr), 0);
            end else begin
                chk(rf_waddr == wa_q[0], "R10", "write register",
                    longint'(rf_waddr), longint'(wa_q[0]));
                checks++;
                if (rf_wdata !== wd_q[0]) begin
                    failures++;
                    $display("FAIL R1/R6 write data actual=%h expected=%h", rf_wdata, wd_q[0]);
                end
                void'(wa_q.pop_front());
                void'(wd_q.pop_front());
            end
        end
    end

    task automatic run_op(input logic [AW-1:0] base, input int im, input int dst,
                          input int k, input int flt, input string tag);
        logic [AW-1:0]   st;
        logic [VLEN-1:0] lo, hi;
        int keff, fat, n;
        bit exp_ill, seen, got_ill, got_flt;
        logic [EIW-1:0] got_fe;
        exp_ill = dst[0];
        keff = (k > NT) ? NT : k;
        st = base + AW'(im * (VLEN / 8));
        fat = -1;
        lo = '0;
        hi = '0;
        flt_en = (flt >= 0);
        flt_addr = st + AW'(4 * flt);
        if (!exp_ill) begin
            for (int i = 0; i < keff; i++) begin
                req_q.push_back(st + AW'(4 * i));
                if (i == flt) begin
                    fat = i;
                    break;
                end
                if (i < NE) lo[32*i +: 32] = memfn(st + AW'(4 * i));
                else        hi[32*(i-NE) +: 32] = memfn(st + AW'(4 * i));
            end
            if (fat < 0) begin
                wa_q.push_back(RIDX_W'(dst));
                wd_q.push_back(lo);
                wa_q.push_back(RIDX_W'(dst + 1));
                wd_q.push_back(hi);
            end
        end
        @(negedge clk);
        start = 1'b1;
        base_addr = base;
        imm = IMM_W'(im);
        dst_reg = RIDX_W'(dst);
        pred_cnt = PCNT_W'(k);
        @(negedge clk);
        start = 1'b0;
        seen = 1'b0; got_ill = 1'b0; got_flt = 1'b0; got_fe = '0;
        n = 0;
        if (done) begin
            seen = 1'b1; got_ill = illegal; got_flt = fault; got_fe = fault_elem;
        end
        while (!seen && n < 500) begin
            @(negedge clk);
            n++;
            if (done) begin
                seen = 1'b1; got_ill = illegal; got_flt = fault; got_fe = fault_elem;
            end
        end
        $display("op %s finished", tag);
        chk(seen, "R10", {tag, " done seen"}, longint'(seen), 1);
        chk(got_ill == exp_ill, "R2", {tag, " illegal"}, longint'(got_ill), longint'(exp_ill));
        chk(got_flt == (fat >= 0), "R9/R5", {tag, " fault"}, longint'(got_flt), longint'(fat >= 0));
        if (fat >= 0)
            chk(int'(got_fe) == fat, "R9", {tag, " fault_elem"}, longint'(got_fe), longint'(fat));
        chk(req_q.size() == 0, "R3/R4", {tag, " requests pending"}, longint'(req_q.size()), 0);
        chk(wa_q.size() == 0, "R10", {tag, " writes pending"}, longint'(wa_q.size()), 0);
        req_q.delete();
        wa_q.delete();
        wd_q.delete();
        flt_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !illegal && !fault && !rf_we && !mem_req_valid, "R10",
            "reset idle outputs", longint'({done, illegal, fault, rf_we, mem_req_valid}), 0);
        run_op(32'h0000_1000,  0,  4,   3, -1, "R3_partial_lo");
        run_op(32'h0000_2000,  1,  6,   0, -1, "R6_none_active");
        run_op(32'h0000_3000,  0,  8, 200, -1, "R3_saturated");
        run_op(32'h0000_4000, -2, 10,   6, -1, "R7_negative_imm_R1_split");
        run_op(32'h0000_5000,  0,  7,   8, -1, "R2_odd_dst");
        run_op(32'h0000_6000,  3, 12,   5,  2, "R9_fault_enabled");
        run_op(32'h0000_7000,  0, 14,   4,  6, "R5_fault_on_disabled");
        run_op(32'h0000_8000, -1,  0,   8,  7, "R9_fault_last");
        run_op(32'h0000_9000,  2, 30,   5, -1, "R8_after_fault");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule